// File: doc/BRIEF.md
# Dual-Compare Buffered PWM Timer

This block is a 16-bit up-counter with two compare values that drives one pulse-width-modulated output. The second compare value closes each period: when the counter reaches it, the output takes a programmable level and the counter restarts from the preload value FFFCh. The first compare value places the other edge inside the period, where the output takes a second programmable level.

While PWM operation runs, compare writes land in shadow registers. They move into the active compare registers only when a period ends, so a period never mixes old and new values. While PWM operation is off, writes go straight to the active registers and the output holds its level.

The counter advances on a tick chosen by a 2-bit clock-select input. The tick is either a fixed division of the system clock or a synchronized rising edge of an external clock pin.

Top module: `pwm_cmp_timer`

## Requirements
- R1: After reset the output is 0, both compare values (active and shadow) are 0000h, PWM operation is off and the counter holds FFFCh.
- R2: On a tick where the counter equals the active compare-1 value, the output takes the level in control bit 2 on the next clock. The output keeps that level for (compare2 − compare1) ticks.
- R3: On a tick where the counter equals the active compare-2 value, the output takes the level in control bit 3 and the counter reloads FFFCh. A period is therefore compare2 + 5 ticks, and the output keeps the control bit 3 level for compare1 + 5 ticks.
- R4: While PWM operation runs, compare writes change nothing in the period in progress. They take effect starting with the period that follows the next compare-2 match.
- R5: clk_sel 00 gives one tick every 4 clocks, 01 every 2, 10 every 8, and 11 one tick per rising edge of ext_clk after synchronization. The counter moves only on ticks.
- R6: PWM operation runs only when control bit 0 (output enable) and control bit 1 (PWM mode) are both set. Otherwise the counter rests at FFFCh.
- R7: While PWM operation is off, the output holds its last level, and compare writes go directly to the active registers, so the first period after enabling already uses them.
- R8: The write port decodes wr_sel: 0 writes compare 1, 1 writes compare 2, 2 writes the control bits from wr_data[3:0]. A write with wr_sel 3 has no effect.
- R9: When both compare values are equal, the compare-2 action takes precedence and the compare-1 level is never applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 compare 1, 1 compare 2, 2 control |
| wr_data | input | 16 | Write data |
| clk_sel | input | 2 | Counter tick source select |
| ext_clk | input | 1 | External clock, asynchronous to clk |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The hardest case to reach from the ports is a compare write that arrives in the middle of a running period. Its effect must stay hidden for exactly one more period. The stimulus waits for the output edge caused by a compare-2 match, which marks the start of a period. It then writes new compare values at once and queues one period of old-value segment lengths followed by new-value ones. The monitor then confirms that the switch happens on the period boundary and not earlier. The equal-compare case is reached by loading identical values and checking that the output never leaves the compare-2 level.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int CNT_W = 16;
  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    SEL_CMP1 = 2'd0,
    SEL_CMP2 = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  typedef enum logic [1:0] {
    TCK_DIV4 = 2'd0,
    TCK_DIV2 = 2'd1,
    TCK_DIV8 = 2'd2,
    TCK_EXT  = 2'd3
  } tsel_e;

  typedef struct packed {
    logic lvl_b;   // bit 3: level on compare-2 match
    logic lvl_a;   // bit 2: level on compare-1 match
    logic pwm_on;  // bit 1: PWM mode
    logic oe;      // bit 0: output enable
  } ctrl_t;
endpackage

// File: rtl/pwmt_tick.sv
module pwmt_tick #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] clk_sel,
  input  logic       ext_clk,
  output logic       tick
);
  import pwmt_pkg::*;
  localparam int DIV_W = 3;

  logic [DIV_W-1:0]       div_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev;
  logic                   tick_d;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= ext_clk;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_comb begin
    case (tsel_e'(clk_sel))
      TCK_DIV2: tick_d = div_q[0];
      TCK_DIV4: tick_d = &div_q[1:0];
      TCK_DIV8: tick_d = &div_q;
      default:  tick_d = sync_q[SYNC_STAGES-1] & ~ext_prev;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      ext_prev <= 1'b0;
      tick     <= 1'b0;
    end else begin
      div_q    <= div_q + 1'b1;
      ext_prev <= sync_q[SYNC_STAGES-1];
      tick     <= tick_d;
    end
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R5
endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs #(
  parameter int CNT_W = pwmt_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              period_end,
  output logic [CNT_W-1:0]  act_c1,
  output logic [CNT_W-1:0]  act_c2,
  output pwmt_pkg::ctrl_t   ctrl,
  output logic              active
);
  import pwmt_pkg::*;

  logic [CNT_W-1:0] shd_c1, shd_c2;
  logic             wr_c1, wr_c2, wr_ct;

  assign active = ctrl.oe & ctrl.pwm_on;
  assign wr_c1  = wr_en && (wsel_e'(wr_sel) == SEL_CMP1);
  assign wr_c2  = wr_en && (wsel_e'(wr_sel) == SEL_CMP2);
  assign wr_ct  = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_c1 <= '0;
      shd_c2 <= '0;
      act_c1 <= '0;
      act_c2 <= '0;
      ctrl   <= '0;
    end else begin
      if (wr_c1) shd_c1 <= wr_data;
      if (wr_c2) shd_c2 <= wr_data;
      if (wr_ct) ctrl   <= ctrl_t'(wr_data[3:0]);
      if (!active) begin
        if (wr_c1) act_c1 <= wr_data;
        if (wr_c2) act_c2 <= wr_data;
      end else if (period_end) begin
        act_c1 <= shd_c1;
        act_c2 <= shd_c2;
      end
    end
  end

  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (rst)
    (active && !period_end) |=> ($stable(act_c1) && $stable(act_c2))); // R4
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!active && wr_c2) |=> (act_c2 == $past(wr_data))); // R7
endmodule

// File: rtl/pwmt_core.sv
module pwmt_core #(
  parameter int              CNT_W   = pwmt_pkg::CNT_W,
  parameter logic [CNT_W-1:0] PRELOAD = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             active,
  input  logic [CNT_W-1:0] act_c1,
  input  logic [CNT_W-1:0] act_c2,
  input  logic             lvl_a,
  input  logic             lvl_b,
  output logic             period_end,
  output logic             pwm_out
);
  logic [CNT_W-1:0] cnt;
  logic             hit_a, hit_b;

  assign hit_b      = active && tick && (cnt == act_c2);
  assign hit_a      = active && tick && (cnt == act_c1);
  assign period_end = hit_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= PRELOAD;
      pwm_out <= 1'b0;
    end else begin
      if (!active || hit_b) cnt <= PRELOAD;
      else if (tick)        cnt <= cnt + 1'b1;
      if (hit_b)      pwm_out <= lvl_b;
      else if (hit_a) pwm_out <= lvl_a;
    end
  end

  AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (rst)
    hit_b |=> (cnt == PRELOAD && pwm_out == $past(lvl_b))); // R3
  AST_EDGE_A_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (hit_a && !hit_b) |=> (pwm_out == $past(lvl_a))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !active |=> ($stable(pwm_out) && cnt == PRELOAD)); // R6
  AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (rst)
    (active && !tick) |=> $stable(cnt)); // R5
  AST_EQUAL_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (hit_a && hit_b) |=> (pwm_out == $past(lvl_b))); // R9
endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer #(
  parameter int               CNT_W       = pwmt_pkg::CNT_W,
  parameter logic [CNT_W-1:0] PRELOAD     = 16'hFFFC,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       clk_sel,
  input  logic             ext_clk,
  output logic             pwm_out
);
  import pwmt_pkg::*;

  logic             tick, active, period_end;
  logic [CNT_W-1:0] act_c1, act_c2;
  ctrl_t            ctrl;

  pwmt_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .ext_clk(ext_clk), .tick(tick)
  );

  pwmt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .period_end(period_end), .act_c1(act_c1), .act_c2(act_c2),
    .ctrl(ctrl), .active(active)
  );

  pwmt_core #(.CNT_W(CNT_W), .PRELOAD(PRELOAD)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .active(active),
    .act_c1(act_c1), .act_c2(act_c2), .lvl_a(ctrl.lvl_a), .lvl_b(ctrl.lvl_b),
    .period_end(period_end), .pwm_out(pwm_out)
  );
endmodule

// File: tb/sim_pwm_cmp_timer.sv
`timescale 1ns/1ps
module sim_pwm_cmp_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  clk_sel = 2'd1;
  logic        ext_clk = 1'b0;
  logic        pwm_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_chg = 0;
  int n_rise = 0;
  int n_fall = 0;
  logic prev_out = 1'b0;

  typedef struct { logic lvl; int len; string req; } seg_t;
  seg_t expq[$];

  always #5 clk = ~clk;

  always begin
    repeat (3) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  pwm_cmp_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .clk_sel(clk_sel), .ext_clk(ext_clk), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures every output segment and scores it against the queue
  always @(negedge clk) begin
    if (rst) begin
      prev_out = pwm_out;
      last_chg = cyc;
    end else begin
      cyc++;
      if (pwm_out !== prev_out) begin
        if (expq.size() > 0) begin
          seg_t e;
          e = expq.pop_front();
          check(e.lvl === prev_out && (cyc - last_chg) == e.len, e.req,
                cyc - last_chg, e.len);
        end
        if (pwm_out) n_rise++; else n_fall++;
        last_chg = cyc;
        prev_out = pwm_out;
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_edge_to(input logic lvl);
    int r = n_rise;
    int f = n_fall;
    if (lvl) wait (n_rise > r); else wait (n_fall > f);
  endtask

  task automatic push_period(input int c1, input int c2, input logic l1,
                             input logic l2, input int t, input string req);
    expq.push_back('{l2, (c1 + 5) * t, req});
    expq.push_back('{l1, (c2 - c1) * t, req});
  endtask

  // driver: configure while idle, align on the period edge, queue expectations
  task automatic run_phase(input logic [1:0] sel, input int t, input int c1,
                           input int c2, input logic l1, input logic l2,
                           input int nper, input string req);
    wr(2'd2, 16'h0000);
    clk_sel = sel;
    wr(2'd0, 16'(c1));
    wr(2'd1, 16'(c2));
    wr(2'd2, {12'd0, l2, l1, 2'b11});
    wait_edge_to(l2);
    for (int i = 0; i < nper; i++) push_period(c1, c2, l1, l2, t, req);
    wait (expq.size() == 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pwm_out === 1'b0, "R1 reset output", int'(pwm_out), 0);

    // R7: compare writes while off reach the active registers directly
    run_phase(2'd1, 2, 10, 30, 1'b0, 1'b1, 3, "R3 R2 R7 div2 period");
    run_phase(2'd0, 4, 3, 12, 1'b0, 1'b1, 2, "R5 div4");
    run_phase(2'd2, 8, 6, 9, 1'b1, 1'b0, 2, "R5 div8 inverted levels");
    run_phase(2'd3, 6, 4, 15, 1'b0, 1'b1, 2, "R5 ext clock");

    // R4: mid-period write held until the period ends; R8 wr_sel 3 ignored
    wr(2'd2, 16'h0000);
    clk_sel = 2'd1;
    wr(2'd0, 16'd8);
    wr(2'd1, 16'd20);
    wr(2'd2, 16'h000B);
    wait_edge_to(1'b1);
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd40);
    wr(2'd3, 16'h0007);
    push_period(8, 20, 1'b0, 1'b1, 2, "R4 old values kept");
    push_period(2, 40, 1'b0, 1'b1, 2, "R4 new values applied");
    push_period(2, 40, 1'b0, 1'b1, 2, "R8 select 3 ignored");
    wait (expq.size() == 0);

    // R6: output enable clear while PWM mode set -> nothing moves
    begin
      int edges;
      wr(2'd2, 16'h0002);
      edges = n_rise + n_fall;
      repeat (400) @(negedge clk);
      check(n_rise + n_fall == edges, "R6 oe clear no edges", n_rise + n_fall - edges, 0);
      wr(2'd2, 16'h0001);
      edges = n_rise + n_fall;
      repeat (400) @(negedge clk);
      check(n_rise + n_fall == edges, "R7 pwm mode clear output held", n_rise + n_fall - edges, 0);
    end

    // R9: equal compares, compare-2 level wins
    begin
      int fl;
      wr(2'd2, 16'h0000);
      wr(2'd0, 16'd10);
      wr(2'd1, 16'd10);
      wr(2'd2, 16'h000B);
      repeat (60) @(negedge clk);
      fl = n_fall;
      check(pwm_out === 1'b1, "R9 equal compare level", int'(pwm_out), 1);
      repeat (120) @(negedge clk);
      check(n_fall == fl && pwm_out === 1'b1, "R9 no compare-1 edge", n_fall - fl, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule